// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block turns a 32.768 kHz time-base enable into periodic events. A 4-bit rate code selects a power-of-two divide ratio. Two enables decide whether the divider runs and where its events go. One enable drives the interrupt path. The other drives a square-wave pulse output.

A 16-bit count advances on every time-base enable, whether the divider is running or not. When the divider is running, an event fires each time the new count is a whole multiple of the selected period. Events therefore stay aligned to the free-running count. A change of rate or enable takes effect at the next aligned boundary, not one full period after the change.

Each event gives a one-clock tick. When the interrupt enable is set, the event also gives an interrupt-raise strobe and an 8-bit set mask for the status register. When the square-wave enable is set, it also gives a one-clock square-wave pulse.

Top module: `periodic_rate_gen`

## Requirements
- R1: A rate code of 0 stops the divider: `per_tick`, `irq_raise`, `sqw_pulse` and `status_set` stay 0 whatever the enables.
- R2: For rate codes 3 to 15, events are 2^(code-1) time-base enables apart (code 3 gives 4, code 15 gives 16384).
- R3: Rate code 1 behaves as code 8 (period 128) and rate code 2 behaves as code 9 (period 256).
- R4: With both `per_irq_en` and `sqwave_en` clear, no event is produced for any rate code.
- R5: The 16-bit count increments on every `base_tick`, including while the divider is stopped. An event fires only when the incremented count has all of its low log2(period) bits at zero, so a rate or enable change takes effect at the next boundary of the new period.
- R6: On an event with `per_irq_en` set, `irq_raise` is 1 and `status_set` is 8'hC0 for that one cycle. Bit 7 is the interrupt-request flag and bit 6 is the periodic flag. Otherwise `irq_raise` is 0 and `status_set` is 8'h00.
- R7: On an event with `sqwave_en` set, `sqw_pulse` is 1 for that one cycle. With `sqwave_en` clear, it stays 0.
- R8: All outputs are registered. An event appears in the clock cycle right after the cycle in which `base_tick` was high and lasts one cycle. No output is ever high in a cycle not preceded by `base_tick`.
- R9: Reset clears the count to zero and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | Single-cycle 32.768 kHz time-base enable |
| rate_sel | input | 4 | Rate code, 0 stops the divider |
| per_irq_en | input | 1 | Periodic interrupt enable |
| sqwave_en | input | 1 | Square-wave output enable |
| per_tick | output | 1 | One-cycle event tick |
| irq_raise | output | 1 | Interrupt-line raise strobe |
| status_set | output | 8 | Status bits to set (bit 7 request, bit 6 periodic) |
| sqw_pulse | output | 1 | One-cycle square-wave pulse |

## Verification
The hardest case to reach is the realignment. A rate or enable change made part-way through a period must fire at the next boundary of the new period, not at a fixed distance from the change. Reaching it needs the free-running count to sit at a known non-aligned value when the change arrives.

The bench resets before each scenario and counts its own `base_tick` pulses. It changes the rate or turns on an enable after a chosen number of pulses, then measures how many pulses pass before the first event. A full-length code-15 run covers the widest mask.

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen #(
  parameter int CNT_W  = 16,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              per_irq_en,
  input  logic              sqwave_en,
  output logic              per_tick,
  output logic              irq_raise,
  output logic [7:0]        status_set,
  output logic              sqw_pulse
);
  localparam int               REMAP_ADD = 7;
  localparam int               IRQ_BIT   = 7;
  localparam int               PER_BIT   = 6;
  localparam logic [7:0]       FLAG_MASK = 8'((1 << IRQ_BIT) | (1 << PER_BIT));
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [CNT_W-1:0]  cnt, cnt_nxt, mask;
  logic [RATE_W-1:0] eff_code;
  logic              running, fire;

  assign eff_code = (rate_sel == RATE_W'(1) || rate_sel == RATE_W'(2))
                    ? rate_sel + RATE_W'(REMAP_ADD) : rate_sel;
  assign mask     = (ONE << (eff_code - RATE_W'(1))) - ONE;
  assign cnt_nxt  = cnt + ONE;
  assign running  = (rate_sel != '0) && (per_irq_en || sqwave_en);
  assign fire     = base_tick && running && ((cnt_nxt & mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      per_tick   <= 1'b0;
      irq_raise  <= 1'b0;
      status_set <= 8'h00;
      sqw_pulse  <= 1'b0;
    end else begin
      if (base_tick) cnt <= cnt_nxt;
      per_tick   <= fire;
      irq_raise  <= fire && per_irq_en;
      status_set <= (fire && per_irq_en) ? FLAG_MASK : 8'h00;
      sqw_pulse  <= fire && sqwave_en;
    end
  end

  assert_no_tick_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |-> $past(rate_sel) != '0);

  assert_tick_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |-> (cnt & $past(mask)) == '0);

  assert_remap_code2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (per_tick && $past(rate_sel) == RATE_W'(2)) |-> cnt[7:0] == 8'd0);

  assert_tick_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |-> ($past(per_irq_en) || $past(sqwave_en)));

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_raise |-> ($past(per_irq_en) && per_tick));

  assert_sqw_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |-> $past(sqwave_en));

  assert_follows_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (per_tick || sqw_pulse || irq_raise) |-> $past(base_tick));

  assert_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |=> !per_tick);
endmodule

// File: tb/tb_periodic_rate_gen.sv
`timescale 1ns/1ps
module tb_periodic_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_tick = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       per_irq_en = 1'b0;
  logic       sqwave_en = 1'b0;
  logic       per_tick, irq_raise, sqw_pulse;
  logic [7:0] status_set;

  int checks = 0;
  int failures = 0;
  int n = 0;
  int ticks_seen = 0;

  always #2.5 clk = ~clk;

  periodic_rate_gen dut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .rate_sel(rate_sel),
    .per_irq_en(per_irq_en), .sqwave_en(sqwave_en), .per_tick(per_tick),
    .irq_raise(irq_raise), .status_set(status_set), .sqw_pulse(sqw_pulse)
  );

  localparam int NV = 10;
  localparam int V_RATE [NV]  = '{3, 0, 1, 2, 6, 4, 5, 15, 7, 8};
  localparam int V_PIE  [NV]  = '{1, 1, 1, 1, 1, 0, 0, 1,  1, 0};
  localparam int V_SQW  [NV]  = '{0, 1, 0, 1, 1, 0, 1, 0,  1, 1};
  localparam int V_PULSE[NV]  = '{20, 40, 256, 512, 100, 64, 64, 16384, 130, 300};
  localparam int V_EXP  [NV]  = '{5, 0, 2, 2, 3, 0, 4, 1, 2, 2};

  function automatic int period_of(input int r);
    int e;
    e = (r == 1 || r == 2) ? r + 7 : r;
    return 1 << (e - 1);
  endfunction

  function automatic string req_of(input int r, input logic pe, input logic se);
    if (r == 0) return "R1";
    if (!pe && !se) return "R4";
    if (r < 3) return "R3";
    return "R2";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    base_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
  endtask

  task automatic pulse();
    bit fire;
    int exp_v, act_v;
    @(negedge clk);
    base_tick = 1'b1;
    @(negedge clk);
    base_tick = 1'b0;
    n++;
    fire = (rate_sel != 0) && (per_irq_en || sqwave_en) &&
           ((n % period_of(int'(rate_sel))) == 0);
    exp_v = {fire, fire && per_irq_en, (fire && per_irq_en) ? 8'hC0 : 8'h00, fire && sqwave_en};
    act_v = {per_tick, irq_raise, status_set, sqw_pulse};
    if (per_tick) ticks_seen++;
    check(act_v == exp_v, {req_of(int'(rate_sel), per_irq_en, sqwave_en), " R6 R7 event"}, act_v, exp_v);
    @(negedge clk);
    act_v = {per_tick, irq_raise, status_set, sqw_pulse};
    check(act_v == 0, "R8 one-cycle", act_v, 0);
  endtask

  initial begin
    #900000;
    failures++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt_p;
    // R9 reset state
    do_reset();
    @(negedge clk);
    check({per_tick, irq_raise, status_set, sqw_pulse} == 0, "R9 reset outputs",
          {per_tick, irq_raise, status_set, sqw_pulse}, 0);

    for (int v = 0; v < NV; v++) begin
      rate_sel = 4'(V_RATE[v]);
      per_irq_en = 1'(V_PIE[v]);
      sqwave_en = 1'(V_SQW[v]);
      do_reset();
      ticks_seen = 0;
      for (int p = 0; p < V_PULSE[v]; p++) pulse();
      check(ticks_seen == V_EXP[v], {req_of(V_RATE[v], 1'(V_PIE[v]), 1'(V_SQW[v])), " total"},
            ticks_seen, V_EXP[v]);
    end

    // R5: rate change mid-period realigns to next boundary of new period
    rate_sel = 4'd3; per_irq_en = 1'b1; sqwave_en = 1'b0;
    do_reset();
    pulse(); pulse();
    rate_sel = 4'd4;
    ticks_seen = 0; cnt_p = 0;
    while (ticks_seen == 0 && cnt_p < 20) begin pulse(); cnt_p++; end
    check(cnt_p == 6, "R5 realign after rate change", cnt_p, 6);

    // R5: count runs while stopped; late enable fires at aligned boundary
    rate_sel = 4'd3; per_irq_en = 1'b0; sqwave_en = 1'b0;
    do_reset();
    for (int p = 0; p < 6; p++) pulse();
    sqwave_en = 1'b1;
    ticks_seen = 0; cnt_p = 0;
    while (ticks_seen == 0 && cnt_p < 20) begin pulse(); cnt_p++; end
    check(cnt_p == 2, "R5 late enable alignment", cnt_p, 2);

    // R1: stopping mid-run suppresses the pending event
    rate_sel = 4'd3; per_irq_en = 1'b1;
    do_reset();
    pulse(); pulse(); pulse();
    rate_sel = 4'd0;
    ticks_seen = 0;
    for (int p = 0; p < 9; p++) pulse();
    check(ticks_seen == 0, "R1 stop mid-run", ticks_seen, 0);

    // R8: no base_tick, no event even at enabled boundary
    rate_sel = 4'd3;
    ticks_seen = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (per_tick || irq_raise || sqw_pulse || status_set != 0) ticks_seen++;
    end
    check(ticks_seen == 0, "R8 idle without base_tick", ticks_seen, 0);

    // R9: reset mid-run restores count to zero
    do_reset();
    ticks_seen = 0; cnt_p = 0;
    while (ticks_seen == 0 && cnt_p < 20) begin pulse(); cnt_p++; end
    check(cnt_p == 4, "R9 count cleared by reset", cnt_p, 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule